// File: doc/BRIEF.md
# Encoder Position Speed Trigger Unit

This block turns the two phase-shifted channels of an incremental encoder on a moving deposition head into a signed position count and a speed figure. It does this with no processor work per encoder edge. Software loads the position at which the next head action must happen. The unit compares that target with the live position on every cycle and fires early, by a lead distance that grows with the measured speed. This lets downstream actuators start in time to act at the target rather than after it.

The unit sits behind a small memory-mapped register port clocked by the 100 MHz system clock. Software writes the target, a position preset, the speed window length and a latency gain. It reads back position, speed and a status word. A hit produces a one-cycle start pulse for the actuator command logic and sets a pending interrupt. The interrupt stays set until software clears it.

Top module: `enc_trig_unit`

Register map (`bus_addr`):

| Address | Register | Access |
|---|---|---|
| 0 | target | read/write |
| 1 | position | read; a write is a preset |
| 2 | speed | read only |
| 3 | window | read/write, reset 100000 |
| 4 | gain | read/write, reset 256 |
| 5 | status | bit0 interrupt pending (write 1 clears), bit1 edge error, bit2 armed, bit3 direction forward |

## Requirements
- R1: Each encoder channel is resynchronised through two flops and then accepted only after it has held a new level for 3 consecutive cycles. A pulse of one cycle changes neither the position nor the error flag.
- R2: Decoding is 4x. Forward motion is the channel sequence (A,B) = 00, 10, 11, 01, 00 and adds one per valid edge. The reverse order subtracts one. The direction of the last valid edge is kept; it is forward after reset.
- R3: A transition in which both channels change at once leaves the position unchanged. It sets an error flag (status bit1) that stays set until reset.
- R4: Writing address 1 loads the written value into the position in the following cycle. The preset takes priority over a same-cycle edge.
- R5: Speed (address 2) is the signed net edge count over a window of N cycles, where N is held at address 3 with a reset value of 100000. It is latched at the end of each window. Writing the window register restarts the window.
- R6: The lead is |speed| × gain / 256, rounded down, where gain is address 4 (16 bits, reset 256). When the last direction is forward, a hit is position + lead ≥ target. When it is reverse, a hit is position − lead ≤ target.
- R7: Writing address 0 loads the target and arms the unit. An armed hit produces exactly one one-cycle `trig_pulse`, and no further pulse occurs until the next target write.
- R8: `irq` rises with the trigger pulse and stays high until a write to address 5 with bit0 set. Writing 0 there leaves it set.
- R9: After reset: position 0, speed 0, target 0, window 100000, gain 256, status 8 (forward, nothing pending), and `irq` and `trig_pulse` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| irq | output | 1 | Pending trigger interrupt |
| trig_pulse | output | 1 | One-cycle start pulse for the actuator command logic |

## Verification
The comparison is driven by a table of moves. Each move either stops short of the target, lands exactly on it, or passes it, in both directions and across zero. This separates a correct compare from one that is off by one or ignores the direction. With speed held at zero, that table isolates the plain compare. A later run at a steady rate of 10 edges per window, forward and then in reverse, shows the pulse arriving about 40 counts early. That separates the speed-based lead from a fixed compare and from a lead with the wrong sign. Directed cases cover the single-cycle glitch, the double-bit edge, the preset, the once-per-target rule and the write-one interrupt clear.

// File: rtl/enc_pkg.sv
package enc_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_FWD  = 2'd1,
    STEP_REV  = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;

  localparam int unsigned REG_TARGET = 0;
  localparam int unsigned REG_POS    = 1;
  localparam int unsigned REG_SPEED  = 2;
  localparam int unsigned REG_WINDOW = 3;
  localparam int unsigned REG_GAIN   = 4;
  localparam int unsigned REG_STATUS = 5;

  // Map a {a,b} channel pair onto its place in the forward cycle 00,10,11,01.
  function automatic logic [1:0] ab_phase(input logic [1:0] ab);
    return {ab[0], ab[1] ^ ab[0]};
  endfunction

  // Classify the move from one channel pair to the next.
  function automatic step_e ab_step(input logic [1:0] prev_ab, input logic [1:0] cur_ab);
    logic [1:0] diff;
    diff = ab_phase(cur_ab) - ab_phase(prev_ab);
    case (diff)
      2'd1:    return STEP_FWD;
      2'd3:    return STEP_REV;
      2'd2:    return STEP_BAD;
      default: return STEP_NONE;
    endcase
  endfunction

endpackage

// File: rtl/enc_input_filter.sv
module enc_input_filter #(
  parameter int FILT_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic clean_out
);
  localparam int CNT_W = $clog2(FILT_CYC + 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q    <= '0;
      hold_cnt  <= '0;
      clean_out <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_in};
      if (sync_q[1] != clean_out) begin
        if (hold_cnt == CNT_W'(FILT_CYC - 1)) begin
          clean_out <= sync_q[1];
          hold_cnt  <= '0;
        end else begin
          hold_cnt <= hold_cnt + 1'b1;
        end
      end else begin
        hold_cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/enc_quad_decoder.sv
module enc_quad_decoder
  import enc_pkg::*;
#(
  parameter int POS_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [1:0]              ab_in,
  input  logic                    preset_wr,
  input  logic signed [POS_W-1:0] preset_val,
  output logic signed [POS_W-1:0] pos,
  output step_e                   step,
  output logic                    dir_fwd,
  output logic                    err_flag
);
  logic [1:0]              prev_ab;
  logic signed [POS_W-1:0] delta;

  assign step  = ab_step(prev_ab, ab_in);
  assign delta = (step == STEP_FWD) ? POS_W'(1) :
                 (step == STEP_REV) ? '1 : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_ab  <= 2'b00;
      pos      <= '0;
      dir_fwd  <= 1'b1;
      err_flag <= 1'b0;
    end else begin
      prev_ab <= ab_in;
      if (preset_wr) pos <= preset_val;
      else           pos <= pos + delta;
      if (step == STEP_FWD) dir_fwd <= 1'b1;
      if (step == STEP_REV) dir_fwd <= 1'b0;
      if (step == STEP_BAD) err_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/enc_speed_window.sv
module enc_speed_window
  import enc_pkg::*;
#(
  parameter int POS_W = 32,
  parameter int WIN_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  step_e                   step,
  input  logic [WIN_W-1:0]        window,
  input  logic                    restart,
  output logic signed [POS_W-1:0] speed,
  output logic                    win_end
);
  logic [WIN_W-1:0]        win_cnt;
  logic signed [POS_W-1:0] acc;
  logic signed [POS_W-1:0] delta;

  assign delta   = (step == STEP_FWD) ? POS_W'(1) :
                   (step == STEP_REV) ? '1 : '0;
  assign win_end = ({1'b0, win_cnt} + 1'b1) >= {1'b0, window};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt <= '0;
      acc     <= '0;
      speed   <= '0;
    end else if (restart) begin
      win_cnt <= '0;
      acc     <= '0;
    end else if (win_end) begin
      speed   <= acc + delta;
      acc     <= '0;
      win_cnt <= '0;
    end else begin
      acc     <= acc + delta;
      win_cnt <= win_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/enc_lead_compare.sv
module enc_lead_compare #(
  parameter int POS_W  = 32,
  parameter int GAIN_W = 16,
  parameter int FRAC_W = 8
) (
  input  logic signed [POS_W-1:0] pos,
  input  logic signed [POS_W-1:0] speed,
  input  logic [GAIN_W-1:0]       gain,
  input  logic signed [POS_W-1:0] target,
  input  logic                    dir_fwd,
  output logic                    hit
);
  localparam int PROD_W = POS_W + GAIN_W;
  localparam int EXT_W  = PROD_W + 2;

  function automatic logic [PROD_W-1:0] lead_of(input logic signed [POS_W-1:0] spd,
                                                input logic [GAIN_W-1:0] g);
    logic [POS_W-1:0]  mag;
    logic [PROD_W-1:0] prod;
    mag  = spd[POS_W-1] ? (~spd + 1'b1) : spd;
    prod = PROD_W'(mag) * PROD_W'(g);
    return prod >> FRAC_W;
  endfunction

  logic [PROD_W-1:0]       lead;
  logic signed [EXT_W-1:0] pos_e, tgt_e, lead_e;

  assign lead   = lead_of(speed, gain);
  assign pos_e  = EXT_W'(pos);
  assign tgt_e  = EXT_W'(target);
  assign lead_e = $signed({2'b00, lead});
  assign hit    = dir_fwd ? ((pos_e + lead_e) >= tgt_e) : ((pos_e - lead_e) <= tgt_e);
endmodule

// File: rtl/enc_trig_unit.sv
module enc_trig_unit
  import enc_pkg::*;
#(
  parameter int POS_W    = 32,
  parameter int WIN_W    = 32,
  parameter int GAIN_W   = 16,
  parameter int FRAC_W   = 8,
  parameter int FILT_CYC = 3,
  parameter int WIN_DEF  = 100000,
  parameter int GAIN_DEF = 256,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_a,
  input  logic              enc_b,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [POS_W-1:0]  bus_wdata,
  output logic [POS_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              trig_pulse
);
  localparam int DATA_W = POS_W;

  // Named internal events, also used by the bound checker.
  logic                    tgt_wr, preset_wr, win_wr, gain_wr, irq_clr;
  logic                    fire_evt, hit, armed, irq_pend, bad_edge;
  logic                    dir_fwd, err_flag, win_end;
  logic signed [POS_W-1:0] pos, speed, target_q;
  logic [WIN_W-1:0]        win_q;
  logic [GAIN_W-1:0]       gain_q;
  logic [1:0]              raw_ab, clean_ab;
  step_e                   step;

  assign tgt_wr    = bus_we && (bus_addr == ADDR_W'(REG_TARGET));
  assign preset_wr = bus_we && (bus_addr == ADDR_W'(REG_POS));
  assign win_wr    = bus_we && (bus_addr == ADDR_W'(REG_WINDOW));
  assign gain_wr   = bus_we && (bus_addr == ADDR_W'(REG_GAIN));
  assign irq_clr   = bus_we && (bus_addr == ADDR_W'(REG_STATUS)) && bus_wdata[0];

  assign raw_ab = {enc_a, enc_b};

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    enc_input_filter #(.FILT_CYC(FILT_CYC)) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (raw_ab[ch]),
      .clean_out(clean_ab[ch])
    );
  end

  enc_quad_decoder #(.POS_W(POS_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .ab_in     (clean_ab),
    .preset_wr (preset_wr),
    .preset_val($signed(bus_wdata)),
    .pos       (pos),
    .step      (step),
    .dir_fwd   (dir_fwd),
    .err_flag  (err_flag)
  );

  assign bad_edge = (step == STEP_BAD);

  enc_speed_window #(.POS_W(POS_W), .WIN_W(WIN_W)) u_spd (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .window (win_q),
    .restart(win_wr),
    .speed  (speed),
    .win_end(win_end)
  );

  enc_lead_compare #(.POS_W(POS_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) u_cmp (
    .pos    (pos),
    .speed  (speed),
    .gain   (gain_q),
    .target (target_q),
    .dir_fwd(dir_fwd),
    .hit    (hit)
  );

  assign fire_evt = armed && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      target_q   <= '0;
      win_q      <= WIN_W'(WIN_DEF);
      gain_q     <= GAIN_W'(GAIN_DEF);
      armed      <= 1'b0;
      irq_pend   <= 1'b0;
      trig_pulse <= 1'b0;
    end else begin
      if (tgt_wr)  target_q <= $signed(bus_wdata);
      if (win_wr)  win_q    <= bus_wdata[WIN_W-1:0];
      if (gain_wr) gain_q   <= bus_wdata[GAIN_W-1:0];
      if (tgt_wr)        armed <= 1'b1;
      else if (fire_evt) armed <= 1'b0;
      if (fire_evt)     irq_pend <= 1'b1;
      else if (irq_clr) irq_pend <= 1'b0;
      trig_pulse <= fire_evt;
    end
  end

  assign irq = irq_pend;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(REG_TARGET): bus_rdata = target_q;
      ADDR_W'(REG_POS):    bus_rdata = pos;
      ADDR_W'(REG_SPEED):  bus_rdata = speed;
      ADDR_W'(REG_WINDOW): bus_rdata = DATA_W'(win_q);
      ADDR_W'(REG_GAIN):   bus_rdata = DATA_W'(gain_q);
      ADDR_W'(REG_STATUS): bus_rdata = DATA_W'({dir_fwd, armed, err_flag, irq_pend});
      default:             bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/enc_trig_unit_chk.sv
module enc_trig_unit_chk #(
  parameter int POS_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    trig_pulse,
  input logic                    irq,
  input logic                    irq_clr,
  input logic                    fire_evt,
  input logic                    tgt_wr,
  input logic                    armed,
  input logic                    preset_wr,
  input logic                    bad_edge,
  input logic                    err_flag,
  input logic signed [POS_W-1:0] pos,
  input logic [POS_W-1:0]        bus_wdata
);
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !preset_wr |=> ((pos == $past(pos)) || (pos == $past(pos) + 1) || (pos == $past(pos) - 1))); // R2

  AST_BAD_EDGE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_edge && !preset_wr) |=> $stable(pos)); // R3

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag); // R3

  AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    preset_wr |=> (pos == $signed($past(bus_wdata)))); // R4

  AST_DISARM_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_evt && !tgt_wr) |=> !armed); // R7

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_pulse && !$past(tgt_wr)) |=> !trig_pulse); // R7

  AST_PULSE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |-> irq); // R8

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq); // R8
endmodule

bind enc_trig_unit enc_trig_unit_chk #(.POS_W(POS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trig_pulse(trig_pulse),
  .irq       (irq),
  .irq_clr   (irq_clr),
  .fire_evt  (fire_evt),
  .tgt_wr    (tgt_wr),
  .armed     (armed),
  .preset_wr (preset_wr),
  .bad_edge  (bad_edge),
  .err_flag  (err_flag),
  .pos       (pos),
  .bus_wdata (bus_wdata)
);

// File: tb/enc_trig_unit_bench.sv
module enc_trig_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_a = 1'b0, enc_b = 1'b0;
  logic        bus_we = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, trig_pulse;

  int n_chk = 0, n_fail = 0;
  int ph = 0;
  int model_pos = 0;
  int pulse_cnt = 0;
  int fire_pos = 0;
  bit done = 0;

  localparam logic [2:0] A_TGT = 3'd0, A_POS = 3'd1, A_SPD = 3'd2,
                         A_WIN = 3'd3, A_GAIN = 3'd4, A_STAT = 3'd5;

  // steps, target, expected position, expected interrupt
  localparam int VEC [8][4] = '{
    '{ 5, 10,  5, 0},
    '{ 5, 10, 10, 1},
    '{-3,  7,  7, 1},
    '{-2,  4,  5, 0},
    '{-8,  0, -3, 1},
    '{ 6,  4,  3, 0},
    '{ 0,  3,  3, 1},
    '{-4, -5, -1, 0}
  };

  always #10 clk = ~clk;

  enc_trig_unit u_enc_trig_unit (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .trig_pulse(trig_pulse)
  );

  always @(negedge clk) begin
    if (trig_pulse) begin
      pulse_cnt = pulse_cnt + 1;
      fire_pos  = model_pos;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input string what, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d..%0d", req, what, act, lo, hi);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output int d);
    @(negedge clk);
    bus_addr = a;
    #1;
    d = int'(bus_rdata);
  endtask

  task automatic drive_phase();
    enc_a = (ph == 1 || ph == 2);
    enc_b = (ph == 2 || ph == 3);
  endtask

  task automatic move(input int n, input int hold, input int settle);
    int cnt;
    cnt = (n < 0) ? -n : n;
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      ph = (n > 0) ? (ph + 1) % 4 : (ph + 3) % 4;
      drive_phase();
      model_pos = model_pos + ((n > 0) ? 1 : -1);
      repeat (hold - 1) @(negedge clk);
    end
    repeat (settle) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      summary();
      $finish;
    end
  end

  initial begin
    int v, pc0, tgt;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R9: reset state
    bus_rd(A_POS, v);  check("R9", "reset position", v, 0);
    bus_rd(A_SPD, v);  check("R9", "reset speed", v, 0);
    bus_rd(A_WIN, v);  check("R9", "reset window", v, 100000);
    bus_rd(A_GAIN, v); check("R9", "reset gain", v, 256);
    bus_rd(A_STAT, v); check("R9", "reset status", v, 8);
    bus_rd(A_TGT, v);  check("R9", "reset target", v, 0);
    check("R9", "reset irq", int'(irq), 0);
    check("R9", "reset trig_pulse", int'(trig_pulse), 0);

    // R2/R6/R7: table of moves and targets at zero speed
    for (int k = 0; k < 8; k++) begin
      move(VEC[k][0], 8, 10);
      bus_wr(A_STAT, 1);
      bus_wr(A_TGT, VEC[k][1]);
      repeat (4) @(negedge clk);
      bus_rd(A_POS, v);
      check("R2", $sformatf("vector %0d position", k), v, VEC[k][2]);
      check("R6", $sformatf("vector %0d irq", k), int'(irq), VEC[k][3]);
    end

    // R1: a single-cycle glitch on A is rejected
    bus_rd(A_POS, pc0);
    @(negedge clk); enc_a = ~enc_a;
    @(negedge clk); enc_a = ~enc_a;
    repeat (12) @(negedge clk);
    bus_rd(A_POS, v);  check("R1", "position after glitch", v, pc0);
    bus_rd(A_STAT, v); check("R1", "error flag after glitch", (v >> 1) & 1, 0);

    // R7/R8: fire once, hold irq, write-one clear (direction is reverse here)
    bus_wr(A_STAT, 1);
    pc0 = pulse_cnt;
    bus_wr(A_TGT, model_pos);
    repeat (4) @(negedge clk);
    check("R7", "pulse on reached target", pulse_cnt - pc0, 1);
    move(-3, 8, 10);
    check("R7", "no second pulse for same target", pulse_cnt - pc0, 1);
    bus_wr(A_STAT, 0);
    check("R8", "irq kept after write of 0", int'(irq), 1);
    bus_wr(A_STAT, 1);
    @(negedge clk);
    check("R8", "irq cleared by write of 1", int'(irq), 0);

    // R4: preset
    bus_wr(A_POS, 1000);
    model_pos = 1000;
    bus_rd(A_POS, v); check("R4", "preset loads position", v, 1000);

    // R3: double-bit transition
    @(negedge clk);
    ph = (ph + 2) % 4;
    drive_phase();
    repeat (12) @(negedge clk);
    bus_rd(A_POS, v);  check("R3", "position held on bad edge", v, 1000);
    bus_rd(A_STAT, v); check("R3", "error flag set", (v >> 1) & 1, 1);
    move(2, 8, 10);
    model_pos = 1002;
    bus_rd(A_POS, v);  check("R3", "counting resumes", v, 1002);
    bus_rd(A_STAT, v); check("R3", "error flag sticky", (v >> 1) & 1, 1);

    // R5/R6: forward lead at 10 edges per window, gain 4.0
    bus_wr(A_WIN, 200);
    bus_wr(A_GAIN, 1024);
    move(40, 20, 0);
    bus_rd(A_SPD, v); check_rng("R5", "forward speed", v, 9, 11);
    pc0 = pulse_cnt;
    tgt = model_pos + 100;
    bus_wr(A_TGT, tgt);
    move(100, 20, 0);
    check("R7", "one forward pulse", pulse_cnt - pc0, 1);
    check_rng("R6", "forward fire position", fire_pos, tgt - 46, tgt - 34);
    check("R8", "irq after forward fire", int'(irq), 1);

    // R5/R6: reverse lead
    bus_wr(A_STAT, 1);
    move(-40, 20, 0);
    bus_rd(A_SPD, v); check_rng("R5", "reverse speed", v, -11, -9);
    pc0 = pulse_cnt;
    tgt = model_pos - 100;
    bus_wr(A_TGT, tgt);
    move(-100, 20, 0);
    check("R7", "one reverse pulse", pulse_cnt - pc0, 1);
    check_rng("R6", "reverse fire position", fire_pos, tgt + 34, tgt + 46);

    done = 1;
    summary();
    $finish;
  end
endmodule